// File: doc/BRIEF.md
# Synchronization Counter Bank

This block keeps a bank of wrapping synchronization counters shared by many requesters. Any requester may read any counter by its index. A requester must first claim a counter before it can change it. Once it owns a counter it can schedule a batch of increments or fast-forward a job that has hung. A set of waiter slots watches the counters. Each slot raises a done flag when its counter reaches a threshold, with the comparison taken modulo the counter width.

Requests arrive on a single register-style port, one per cycle. Each request carries an opcode, a counter index, a requester identifier and a count. An accepted request returns one response word on the next cycle. A refused request instead gives a one-cycle error pulse. An increment request does not change the counter at once. It adds its count to a per-counter pending total, and a stepping engine drains that total one unit per clock. Each single step is therefore atomic, and the values in between can be read. A fast-forward applies the whole remaining total in one cycle, which is how a job that has timed out gets reaped.

Top module: `sync_bank`

## Requirements
- R1: After reset every counter and pending total is zero, no counter has an owner, every waiter slot is invalid with its done flag low, and neither rspValid nor errPulse is high.
- R2: Opcode 0 (read) is accepted from any requester for any counter in range. On the cycle after the request, rspValid is high and rspData holds the counter as it was before any step landing on that same clock edge.
- R3: Opcode 3 (claim) succeeds when the counter has no owner, or when its owner is the requester itself. The requester then becomes the owner and the response carries the current value. A claim on a counter owned by another requester is refused.
- R4: A mutation request (increment or fast-forward) from a requester that is not the owner, including any request on an unowned counter, is dropped. The same applies to a refused claim. Such a request gives errPulse high for exactly one cycle with rspValid low, and leaves every counter unchanged.
- R5: Opcode 1 (increment) from the owner with count N responds with the fence value: the counter value plus its pending total plus N. N is added to the pending total.
- R6: A pending total is applied one unit per clock, starting on the edge after the increment is accepted. A counter never moves by more than one per cycle unless it is fast-forwarded, and every intermediate value is readable.
- R7: Opcode 2 (fast-forward) from the owner sets the counter to its value plus its pending total and clears the total. The response carries that final value. When a single step and a fast-forward hit the same counter in the same cycle, the fast-forward wins and no extra step is added.
- R8: Counters wrap from all ones to zero.
- R9: A valid waiter slot is met when (counter minus threshold), read as a signed number of the counter width, is zero or positive.
- R10: Loading a waiter slot makes it valid and clears its done flag. If the threshold is already met, done rises on the following clock edge.
- R11: Done is sticky. It stays high even if the signed distance later turns negative, until the slot is cleared, which also invalidates it, or reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | 0 read, 1 increment, 2 fast-forward, 3 claim |
| reqIdx | input | IDX_W | Counter index |
| reqId | input | ID_W | Requester identifier |
| reqCount | input | VAL_W | Increment count for opcode 1 |
| rspValid | output | 1 | Response word valid (one cycle after request) |
| rspData | output | VAL_W | Read value, fence value or final value |
| errPulse | output | 1 | One-cycle pulse for a refused request |
| wLoad | input | 1 | Load waiter slot wSlot |
| wClear | input | 1 | Clear waiter slot wSlot |
| wSlot | input | SLOT_W | Waiter slot select |
| wCtr | input | IDX_W | Counter watched by the loaded slot |
| wThresh | input | VAL_W | Threshold for the loaded slot |
| waitDone | output | NUM_WAITERS | Sticky done flag per waiter slot |

## Verification
A table of requests covers reads, claims, increments and fast-forwards from both owners and strangers. It tells accepted work apart from refused work, and a later read proves that a refused request left the value untouched. Reads issued back to back behind a four-count increment tell a single-step engine apart from one that jumps. A fast-forward issued right after a ten-count increment, while a step is due, tells correct priority apart from a merged step. A counter driven to all ones, with waiters whose thresholds sit on both sides of the signed half-range, separates signed distance from plain unsigned comparison. It also shows the wrap to zero and shows that done stays set after the distance turns negative.

// File: rtl/sync_bank_pkg.sv
`timescale 1ns/1ps
package sync_bank_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_INCR  = 2'd1,
    OP_FFWD  = 2'd2,
    OP_CLAIM = 2'd3
  } req_op_e;

  // Strobes issued by the control toward the counter datapath
  typedef struct packed {
    logic readOut;  // return current value
    logic addPend;  // add count to pending total, return fence
    logic fastFwd;  // apply whole pending total now
  } dp_strobe_t;

endpackage

// File: rtl/sync_bank_ctl.sv
`timescale 1ns/1ps
module sync_bank_ctl
  import sync_bank_pkg::*;
#(
  parameter int NUM_CTRS = 8,
  parameter int ID_W     = 2,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic [ID_W-1:0]  reqId,
  output dp_strobe_t       strobe,
  output logic             errPulse
);

  localparam logic [IDX_W:0] CTR_LIMIT = NUM_CTRS[IDX_W:0];

  logic [NUM_CTRS-1:0] ownValid;
  logic [ID_W-1:0]     ownId [NUM_CTRS];

  logic             inRange;
  logic [IDX_W-1:0] idxSafe;
  logic             ownerHit;
  logic             freeOrMine;
  logic             claimTake;
  logic             errNext;
  req_op_e          op;

  always_comb begin
    op         = req_op_e'(reqOp);
    inRange    = ({1'b0, reqIdx} < CTR_LIMIT);
    idxSafe    = inRange ? reqIdx : '0;
    ownerHit   = ownValid[idxSafe] && (ownId[idxSafe] == reqId);
    freeOrMine = !ownValid[idxSafe] || ownerHit;
    strobe     = '0;
    errNext    = 1'b0;
    if (reqValid) begin
      if (!inRange) begin
        errNext = 1'b1;
      end else begin
        case (op)
          OP_READ:  strobe.readOut = 1'b1;
          OP_CLAIM: if (freeOrMine) strobe.readOut = 1'b1; else errNext = 1'b1;
          OP_INCR:  if (ownerHit)   strobe.addPend = 1'b1; else errNext = 1'b1;
          OP_FFWD:  if (ownerHit)   strobe.fastFwd = 1'b1; else errNext = 1'b1;
          default:  errNext = 1'b1;
        endcase
      end
    end
    claimTake = reqValid && inRange && (op == OP_CLAIM) && freeOrMine;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownValid <= '0;
      errPulse <= 1'b0;
      for (int i = 0; i < NUM_CTRS; i++) ownId[i] <= '0;
    end else begin
      errPulse <= errNext;
      if (claimTake) begin
        ownValid[idxSafe] <= 1'b1;
        ownId[idxSafe]    <= reqId;
      end
    end
  end

endmodule

// File: rtl/sync_bank_dp.sv
`timescale 1ns/1ps
module sync_bank_dp
  import sync_bank_pkg::*;
#(
  parameter int NUM_CTRS = 8,
  parameter int VAL_W    = 32,
  parameter int IDX_W    = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dp_strobe_t                strobe,
  input  logic [IDX_W-1:0]          reqIdx,
  input  logic [VAL_W-1:0]          reqCount,
  output logic                      rspValid,
  output logic [VAL_W-1:0]          rspData,
  output logic [NUM_CTRS*VAL_W-1:0] ctrFlat
);

  logic [VAL_W-1:0]    ctrVal  [NUM_CTRS];
  logic [VAL_W-1:0]    ctrPend [NUM_CTRS];
  logic [NUM_CTRS-1:0] selVec;
  logic [NUM_CTRS-1:0] stepVec;
  logic [VAL_W-1:0]    curVal;
  logic [VAL_W-1:0]    curPend;
  logic [VAL_W-1:0]    rspNext;

  always_comb begin
    curVal  = ctrVal[reqIdx];
    curPend = ctrPend[reqIdx];
    if (strobe.readOut)      rspNext = curVal;
    else if (strobe.addPend) rspNext = curVal + curPend + reqCount;
    else                     rspNext = curVal + curPend;
    for (int i = 0; i < NUM_CTRS; i++) begin
      selVec[i]  = (reqIdx == IDX_W'(i));
      stepVec[i] = |ctrPend[i];
    end
  end

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_flat
    assign ctrFlat[g*VAL_W +: VAL_W] = ctrVal[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      for (int i = 0; i < NUM_CTRS; i++) begin
        ctrVal[i]  <= '0;
        ctrPend[i] <= '0;
      end
    end else begin
      rspValid <= |strobe;
      rspData  <= rspNext;
      for (int i = 0; i < NUM_CTRS; i++) begin
        if (strobe.fastFwd && selVec[i]) begin
          ctrVal[i]  <= ctrVal[i] + ctrPend[i];
          ctrPend[i] <= '0;
        end else begin
          ctrVal[i]  <= ctrVal[i] + VAL_W'(stepVec[i]);
          ctrPend[i] <= ctrPend[i] - VAL_W'(stepVec[i])
                        + ((strobe.addPend && selVec[i]) ? reqCount : '0);
        end
      end
    end
  end

endmodule

// File: rtl/sync_bank_wait.sv
`timescale 1ns/1ps
module sync_bank_wait #(
  parameter int NUM_CTRS    = 8,
  parameter int NUM_WAITERS = 4,
  parameter int VAL_W       = 32,
  parameter int IDX_W       = 3,
  parameter int SLOT_W      = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wLoad,
  input  logic                      wClear,
  input  logic [SLOT_W-1:0]         wSlot,
  input  logic [IDX_W-1:0]          wCtr,
  input  logic [VAL_W-1:0]          wThresh,
  input  logic [NUM_CTRS*VAL_W-1:0] ctrFlat,
  output logic [NUM_WAITERS-1:0]    waitDone
);

  logic [NUM_WAITERS-1:0] slotValid;
  logic [IDX_W-1:0]       slotCtr [NUM_WAITERS];
  logic [VAL_W-1:0]       slotThr [NUM_WAITERS];
  logic [VAL_W-1:0]       watchVal [NUM_WAITERS];
  logic [VAL_W-1:0]       gapVal [NUM_WAITERS];
  logic [NUM_WAITERS-1:0] metVec;
  logic [NUM_WAITERS-1:0] loadHit;
  logic [NUM_WAITERS-1:0] clearHit;

  always_comb begin
    for (int s = 0; s < NUM_WAITERS; s++) begin
      watchVal[s] = ctrFlat[slotCtr[s]*VAL_W +: VAL_W];
      gapVal[s]   = watchVal[s] - slotThr[s];
      metVec[s]   = slotValid[s] && !gapVal[s][VAL_W-1];
      loadHit[s]  = wLoad  && (wSlot == SLOT_W'(s));
      clearHit[s] = wClear && (wSlot == SLOT_W'(s));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      waitDone  <= '0;
      for (int s = 0; s < NUM_WAITERS; s++) begin
        slotCtr[s] <= '0;
        slotThr[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NUM_WAITERS; s++) begin
        if (loadHit[s]) begin
          slotValid[s] <= 1'b1;
          slotCtr[s]   <= wCtr;
          slotThr[s]   <= wThresh;
          waitDone[s]  <= 1'b0;
        end else if (clearHit[s]) begin
          slotValid[s] <= 1'b0;
          waitDone[s]  <= 1'b0;
        end else if (metVec[s]) begin
          waitDone[s]  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sync_bank.sv
`timescale 1ns/1ps
module sync_bank
  import sync_bank_pkg::*;
#(
  parameter int NUM_CTRS    = 8,
  parameter int NUM_WAITERS = 4,
  parameter int ID_W        = 2,
  parameter int VAL_W       = 32,
  localparam int IDX_W      = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1,
  localparam int SLOT_W     = (NUM_WAITERS > 1) ? $clog2(NUM_WAITERS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [1:0]             reqOp,
  input  logic [IDX_W-1:0]       reqIdx,
  input  logic [ID_W-1:0]        reqId,
  input  logic [VAL_W-1:0]       reqCount,
  output logic                   rspValid,
  output logic [VAL_W-1:0]       rspData,
  output logic                   errPulse,
  input  logic                   wLoad,
  input  logic                   wClear,
  input  logic [SLOT_W-1:0]      wSlot,
  input  logic [IDX_W-1:0]       wCtr,
  input  logic [VAL_W-1:0]       wThresh,
  output logic [NUM_WAITERS-1:0] waitDone
);

  dp_strobe_t                strobe;
  logic [NUM_CTRS*VAL_W-1:0] ctrFlat;

  sync_bank_ctl #(.NUM_CTRS(NUM_CTRS), .ID_W(ID_W), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqIdx(reqIdx), .reqId(reqId), .strobe(strobe), .errPulse(errPulse)
  );

  sync_bank_dp #(.NUM_CTRS(NUM_CTRS), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqIdx(reqIdx),
    .reqCount(reqCount), .rspValid(rspValid), .rspData(rspData),
    .ctrFlat(ctrFlat)
  );

  sync_bank_wait #(.NUM_CTRS(NUM_CTRS), .NUM_WAITERS(NUM_WAITERS),
                   .VAL_W(VAL_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_wait (
    .clk(clk), .rstN(rstN), .wLoad(wLoad), .wClear(wClear), .wSlot(wSlot),
    .wCtr(wCtr), .wThresh(wThresh), .ctrFlat(ctrFlat), .waitDone(waitDone)
  );

endmodule

// File: rtl/sync_bank_checker.sv
`timescale 1ns/1ps
module sync_bank_checker #(
  parameter int NUM_CTRS    = 8,
  parameter int NUM_WAITERS = 4,
  parameter int VAL_W       = 32,
  parameter int SLOT_W      = 2
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      reqValid,
  input logic [1:0]                reqOp,
  input logic                      wLoad,
  input logic                      wClear,
  input logic [SLOT_W-1:0]         wSlot,
  input logic                      rspValid,
  input logic                      errPulse,
  input logic [NUM_WAITERS-1:0]    waitDone,
  input logic [NUM_CTRS*VAL_W-1:0] ctrFlat
);

  logic ffwdReq;
  assign ffwdReq = reqValid && (reqOp == 2'd2);

  // R4: a refused request never also produces a response
  p_err_no_rsp_r4: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !rspValid);

  // R4: an error pulse only follows a request
  p_err_after_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(reqValid));

  // R2: a response only follows a request
  p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid));

  for (genvar c = 0; c < NUM_CTRS; c++) begin : g_ctr
    // R6: without a fast-forward a counter moves by zero or one
    p_step_one_r6: assert property (@(posedge clk) disable iff (!rstN)
      !$past(ffwdReq) |->
        ((ctrFlat[c*VAL_W +: VAL_W] == $past(ctrFlat[c*VAL_W +: VAL_W])) ||
         (ctrFlat[c*VAL_W +: VAL_W] == $past(ctrFlat[c*VAL_W +: VAL_W]) + VAL_W'(1))));
  end

  for (genvar s = 0; s < NUM_WAITERS; s++) begin : g_slot
    // R10: a load leaves done low right after it
    p_load_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
      (wLoad && (wSlot == SLOT_W'(s))) |=> !waitDone[s]);

    // R11: done holds unless the slot is loaded or cleared
    p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
      (waitDone[s] && !((wLoad || wClear) && (wSlot == SLOT_W'(s)))) |=> waitDone[s]);
  end

endmodule

bind sync_bank sync_bank_checker #(
  .NUM_CTRS(NUM_CTRS), .NUM_WAITERS(NUM_WAITERS), .VAL_W(VAL_W), .SLOT_W(SLOT_W)
) u_check (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .wLoad(wLoad), .wClear(wClear), .wSlot(wSlot), .rspValid(rspValid),
  .errPulse(errPulse), .waitDone(waitDone), .ctrFlat(ctrFlat)
);

// File: tb/sync_bank_bench.sv
`timescale 1ns/1ps
module sync_bank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = '0;
  logic [2:0]  reqIdx = '0;
  logic [1:0]  reqId = '0;
  logic [31:0] reqCount = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        errPulse;
  logic        wLoad = 1'b0;
  logic        wClear = 1'b0;
  logic [1:0]  wSlot = '0;
  logic [2:0]  wCtr = '0;
  logic [31:0] wThresh = '0;
  logic [3:0]  waitDone;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  sync_bank u_sync_bank (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqIdx(reqIdx), .reqId(reqId), .reqCount(reqCount),
    .rspValid(rspValid), .rspData(rspData), .errPulse(errPulse),
    .wLoad(wLoad), .wClear(wClear), .wSlot(wSlot), .wCtr(wCtr),
    .wThresh(wThresh), .waitDone(waitDone)
  );

  // {op, idx, id, count, expErr, expData}
  localparam int NV = 17;
  localparam logic [71:0] VEC [NV] = '{
    {2'd0, 3'd3, 2'd1, 32'd0, 1'b0, 32'd0},   // read unowned
    {2'd1, 3'd3, 2'd1, 32'd1, 1'b1, 32'd0},   // incr on unowned
    {2'd3, 3'd3, 2'd1, 32'd0, 1'b0, 32'd0},   // claim
    {2'd3, 3'd3, 2'd2, 32'd0, 1'b1, 32'd0},   // claim by stranger
    {2'd1, 3'd3, 2'd2, 32'd1, 1'b1, 32'd0},   // incr by stranger
    {2'd1, 3'd3, 2'd1, 32'd3, 1'b0, 32'd3},   // incr 3
    {2'd0, 3'd3, 2'd0, 32'd0, 1'b0, 32'd3},
    {2'd3, 3'd5, 2'd2, 32'd0, 1'b0, 32'd0},
    {2'd1, 3'd5, 2'd2, 32'd5, 1'b0, 32'd5},
    {2'd0, 3'd5, 2'd3, 32'd0, 1'b0, 32'd5},
    {2'd1, 3'd3, 2'd1, 32'd0, 1'b0, 32'd3},   // incr 0
    {2'd0, 3'd3, 2'd2, 32'd0, 1'b0, 32'd3},
    {2'd3, 3'd3, 2'd1, 32'd0, 1'b0, 32'd3},   // reclaim own
    {2'd2, 3'd5, 2'd1, 32'd0, 1'b1, 32'd0},   // ffwd by stranger
    {2'd0, 3'd5, 2'd0, 32'd0, 1'b0, 32'd5},
    {2'd2, 3'd3, 2'd1, 32'd0, 1'b0, 32'd3},   // ffwd with nothing pending
    {2'd0, 3'd3, 2'd1, 32'd0, 1'b0, 32'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a negedge, return at the next negedge with the response visible
  task automatic doReq(input logic [1:0] op, input logic [2:0] idx,
                       input logic [1:0] id, input logic [31:0] cnt);
    reqValid = 1'b1; reqOp = op; reqIdx = idx; reqId = id; reqCount = cnt;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic loadW(input logic [1:0] slot, input logic [2:0] ctr, input logic [31:0] thr);
    wLoad = 1'b1; wSlot = slot; wCtr = ctr; wThresh = thr;
    @(negedge clk);
    wLoad = 1'b0;
  endtask

  task automatic clrW(input logic [1:0] slot);
    wClear = 1'b1; wSlot = slot;
    @(negedge clk);
    wClear = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rspValid", 32'(rspValid), 32'd0);
    chk("R1 errPulse", 32'(errPulse), 32'd0);
    chk("R1 waitDone", 32'(waitDone), 32'd0);
    doReq(2'd0, 3'd0, 2'd0, 32'd0);
    chk("R1 counter zero", rspData, 32'd0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [1:0]  vOp;
      logic        vErr;
      logic [31:0] vExp;
      string       tag;
      vOp  = VEC[k][71:70];
      vErr = VEC[k][32];
      vExp = VEC[k][31:0];
      if (vErr)              tag = "R4";
      else if (vOp == 2'd0)  tag = "R2";
      else if (vOp == 2'd1)  tag = "R5";
      else if (vOp == 2'd2)  tag = "R7";
      else                   tag = "R3";
      doReq(vOp, VEC[k][69:67], VEC[k][66:65], VEC[k][64:33]);
      chk($sformatf("%s vec%0d err", tag, k), 32'(errPulse), 32'(vErr));
      chk($sformatf("%s vec%0d valid", tag, k), 32'(rspValid), 32'(!vErr));
      if (!vErr) chk($sformatf("%s vec%0d data", tag, k), rspData, vExp);
      repeat (6) @(negedge clk);
    end

    // R6: one step per clock, intermediate values readable
    doReq(2'd3, 3'd1, 2'd0, 32'd0);
    chk("R3 claim ctr1", rspData, 32'd0);
    doReq(2'd1, 3'd1, 2'd0, 32'd4);
    chk("R5 fence 4", rspData, 32'd4);
    for (int k = 0; k < 5; k++) begin
      doReq(2'd0, 3'd1, 2'd2, 32'd0);
      chk($sformatf("R6 step read %0d", k), rspData, 32'(k));
    end

    // R7: fast-forward while a step is due, fast-forward wins
    doReq(2'd1, 3'd1, 2'd0, 32'd10);
    chk("R5 fence 14", rspData, 32'd14);
    doReq(2'd2, 3'd1, 2'd0, 32'd0);
    chk("R7 ffwd final", rspData, 32'd14);
    repeat (3) @(negedge clk);
    doReq(2'd0, 3'd1, 2'd1, 32'd0);
    chk("R7 no extra step", rspData, 32'd14);

    // R4: stranger fast-forward leaves the value alone
    doReq(2'd2, 3'd1, 2'd2, 32'd0);
    chk("R4 ffwd stranger err", 32'(errPulse), 32'd1);
    @(negedge clk);
    doReq(2'd0, 3'd1, 2'd2, 32'd0);
    chk("R4 value kept", rspData, 32'd14);

    // R8/R9/R10/R11: wraparound and waiters
    doReq(2'd3, 3'd2, 2'd3, 32'd0);
    chk("R3 claim ctr2", rspData, 32'd0);
    doReq(2'd1, 3'd2, 2'd3, 32'hFFFF_FFFF);
    chk("R5 fence max", rspData, 32'hFFFF_FFFF);
    doReq(2'd2, 3'd2, 2'd3, 32'd0);
    chk("R7 ffwd to max", rspData, 32'hFFFF_FFFF);
    @(negedge clk);
    doReq(2'd0, 3'd2, 2'd0, 32'd0);
    chk("R8 at max", rspData, 32'hFFFF_FFFF);

    loadW(2'd1, 3'd2, 32'hFFFF_FFFF);
    chk("R10 done low after load", 32'(waitDone[1]), 32'd0);
    @(negedge clk);
    chk("R10 done next edge", 32'(waitDone[1]), 32'd1);
    loadW(2'd0, 3'd2, 32'h0000_0000);
    loadW(2'd2, 3'd2, 32'h8000_0000);
    loadW(2'd3, 3'd2, 32'h7FFF_FFFF);
    repeat (2) @(negedge clk);
    chk("R9 signed distance", 32'(waitDone), 32'b0110);

    doReq(2'd1, 3'd2, 2'd3, 32'd1);
    chk("R8 fence wraps", rspData, 32'd0);
    repeat (3) @(negedge clk);
    chk("R11 sticky after wrap", 32'(waitDone), 32'b0111);
    doReq(2'd0, 3'd2, 2'd1, 32'd0);
    chk("R8 wrapped to zero", rspData, 32'd0);

    clrW(2'd2);
    chk("R11 clear drops done", 32'(waitDone), 32'b0011);
    @(negedge clk);
    chk("R11 cleared stays low", 32'(waitDone), 32'b0011);
    loadW(2'd2, 3'd2, 32'd0);
    chk("R10 reload low", 32'(waitDone), 32'b0011);
    @(negedge clk);
    chk("R10 reload met", 32'(waitDone), 32'b0111);

    summary();
    $finish;
  end

endmodule